// File: doc/BRIEF.md
# Signed Dot-Product Accumulate Engine

The engine multiplies two arrays of signed elements pairwise and adds every product into a 96-bit signed accumulator. The accumulator is held as three register-width words: an upper word, a middle word and a lower word. A start pulse loads two array pointers, an element count, the accumulator words and two flags (sign and overflow) from the caller. The engine then walks both arrays through one shared read port and returns the updated pointers, the remaining count (zero), the new accumulator and the new flags. Elements are 1, 2 or 4 bytes wide and are sign-extended before they are multiplied.

A second command is selected on the same start pulse: saturate. When the overflow flag handed in is set, saturate replaces the accumulator with a fixed clamp pattern. The sign flag picks which pattern is used. When the overflow flag is clear, saturate leaves everything as it was. Both commands report completion with a one-cycle `done` strobe at the end of a `busy` window. The results stay on the outputs until the next accepted start.

Top module: `dotmac_engine`

## Requirements
- R1: An accumulate command (`cmd`=0) with `count_in`=0 changes nothing. Pointers, count, all three accumulator words and both flags come out equal to the inputs, including a set overflow flag.
- R2: Each step reads the element at `ptr_a`, then the element at `ptr_b`. The width comes from `elem_sz`: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. The element sits right-justified in `mem_rdata`, bits above its width are ignored, and it is sign-extended.
- R3: The accumulator {`acc_hi`,`acc_mid`,`acc_lo`} is a 96-bit two's-complement value. Each signed product, sign-extended to 96 bits, is added into it. A carry out of the lower 64 bits raises `acc_hi`; a borrow lowers it.
- R4: After each step both pointers advance by the element width in bytes and the count drops by one. The run ends when the count reaches zero.
- R5: When an accumulate with a nonzero count is accepted, the overflow flag clears on the next cycle. At the end, `flag_s` equals the top bit of `acc_hi`, and `flag_o` is set exactly when `acc_hi` is neither all-zeros nor all-ones.
- R6: Saturate (`cmd`=1) with the overflow and sign inputs both set loads `acc_hi`=0x00000000, `acc_mid`=0x7FFFFFFF, `acc_lo`=0xFFFFFFFF.
- R7: Saturate with overflow set and sign clear loads `acc_hi`=0xFFFFFFFF, `acc_mid`=0x80000000, `acc_lo`=0x00000000. Pointers, count and flags pass through unchanged under either saturate case.
- R8: Saturate with the overflow input clear changes nothing.
- R9: `busy` rises on the cycle after an accepted start. `done` is high for exactly one cycle, while `busy` is high. A start while `busy` is high is ignored. `done` appears 3N+1 cycles after the start edge for an accumulate of N>0 elements, and 1 cycle after it otherwise.
- R10: Reads are issued only while `busy` is high and `done` is low. An accumulate of N elements issues exactly 2N reads. Read data is taken one cycle after the read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when not busy |
| cmd | input | 1 | 0 = accumulate, 1 = saturate |
| elem_sz | input | 2 | Element width code |
| ptr_a_in | input | REG_W | First array pointer to load |
| ptr_b_in | input | REG_W | Second array pointer to load |
| count_in | input | REG_W | Element count to load |
| acc_hi_in | input | REG_W | Accumulator upper word to load |
| acc_mid_in | input | REG_W | Accumulator middle word to load |
| acc_lo_in | input | REG_W | Accumulator lower word to load |
| flag_s_in | input | 1 | Sign flag to load |
| flag_o_in | input | 1 | Overflow flag to load |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| ptr_a | output | REG_W | First array pointer |
| ptr_b | output | REG_W | Second array pointer |
| count | output | REG_W | Remaining element count |
| acc_hi | output | REG_W | Accumulator upper word |
| acc_mid | output | REG_W | Accumulator middle word |
| acc_lo | output | REG_W | Accumulator lower word |
| flag_s | output | 1 | Sign flag |
| flag_o | output | 1 | Overflow flag |
| mem_rd_en | output | 1 | Read request |
| mem_addr | output | REG_W | Read byte address |
| mem_size | output | 2 | Width code of the current read |
| mem_rdata | input | REG_W | Read data, valid one cycle after the request |

## Verification
The bench builds the engine with its default 32-bit register width and attaches a 256-byte memory model. The model always returns four consecutive bytes, so narrow reads arrive with live data above the element. This exercises the ignoring of upper bits under every width code.

At that width the bench sweeps:
- a dense grid of signed byte pairs, covering both extremes of the element range;
- every width code, including the spare one, across counts of one to six with several starting accumulators;
- hand-built carry and borrow cases that push the upper word out of range;
- all three saturate branches.

// File: rtl/dotmac_pkg.sv
package dotmac_pkg;

  typedef enum logic {
    CMD_MAC = 1'b0,
    CMD_SAT = 1'b1
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FETCH_A = 3'd1,
    ST_FETCH_B = 3'd2,
    ST_ACC     = 3'd3,
    ST_FIN     = 3'd4
  } state_e;

  // Byte width of an element for a width code; the spare code acts as a word.
  function automatic logic [2:0] elem_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    elem_bytes = 3'd1;
      2'd1:    elem_bytes = 3'd2;
      default: elem_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dotmac_sext.sv
module dotmac_sext #(
  parameter int REG_W = 32
) (
  input  logic [1:0]       sz,
  input  logic [REG_W-1:0] raw,
  output logic [REG_W-1:0] val
);

  logic signed [7:0]  b8;
  logic signed [15:0] h16;
  logic signed [31:0] w32;

  assign b8  = raw[7:0];
  assign h16 = raw[15:0];
  assign w32 = raw[31:0];

  always_comb begin
    case (sz)
      2'd0:    val = REG_W'(b8);
      2'd1:    val = REG_W'(h16);
      default: val = REG_W'(w32);
    endcase
  end

endmodule

// File: rtl/dotmac_accum.sv
module dotmac_accum #(
  parameter int REG_W = 32
) (
  input  logic [REG_W-1:0] hi,
  input  logic [REG_W-1:0] mid,
  input  logic [REG_W-1:0] lo,
  input  logic [REG_W-1:0] op_a,
  input  logic [REG_W-1:0] op_b,
  output logic [REG_W-1:0] sum_hi,
  output logic [REG_W-1:0] sum_mid,
  output logic [REG_W-1:0] sum_lo,
  output logic             sum_neg,
  output logic             sum_ovf
);

  localparam int PROD_W = 2 * REG_W;
  localparam int ACC_W  = 3 * REG_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc_cur;
  logic signed [ACC_W-1:0]  addend;
  logic signed [ACC_W-1:0]  acc_new;

  always_comb begin
    prod    = $signed(op_a) * $signed(op_b);
    acc_cur = {hi, mid, lo};
    addend  = ACC_W'(prod);
    acc_new = acc_cur + addend;
  end

  assign sum_hi  = acc_new[ACC_W-1 -: REG_W];
  assign sum_mid = acc_new[PROD_W-1 -: REG_W];
  assign sum_lo  = acc_new[REG_W-1:0];
  assign sum_neg = acc_new[ACC_W-1];
  // Upper word carries more than sign extension of the lower 64 bits.
  assign sum_ovf = (|sum_hi) & ~(&sum_hi);

endmodule

// File: rtl/dotmac_clamp.sv
module dotmac_clamp #(
  parameter int REG_W = 32
) (
  input  logic             neg_sel,
  output logic [REG_W-1:0] cl_hi,
  output logic [REG_W-1:0] cl_mid,
  output logic [REG_W-1:0] cl_lo
);

  always_comb begin
    if (neg_sel) begin
      cl_hi  = '0;
      cl_mid = {1'b0, {(REG_W-1){1'b1}}};
      cl_lo  = '1;
    end else begin
      cl_hi  = '1;
      cl_mid = {1'b1, {(REG_W-1){1'b0}}};
      cl_lo  = '0;
    end
  end

endmodule

// File: rtl/dotmac_engine.sv
module dotmac_engine
  import dotmac_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmd,
  input  logic [1:0]       elem_sz,
  input  logic [REG_W-1:0] ptr_a_in,
  input  logic [REG_W-1:0] ptr_b_in,
  input  logic [REG_W-1:0] count_in,
  input  logic [REG_W-1:0] acc_hi_in,
  input  logic [REG_W-1:0] acc_mid_in,
  input  logic [REG_W-1:0] acc_lo_in,
  input  logic             flag_s_in,
  input  logic             flag_o_in,
  output logic             busy,
  output logic             done,
  output logic [REG_W-1:0] ptr_a,
  output logic [REG_W-1:0] ptr_b,
  output logic [REG_W-1:0] count,
  output logic [REG_W-1:0] acc_hi,
  output logic [REG_W-1:0] acc_mid,
  output logic [REG_W-1:0] acc_lo,
  output logic             flag_s,
  output logic             flag_o,
  output logic             mem_rd_en,
  output logic [REG_W-1:0] mem_addr,
  output logic [1:0]       mem_size,
  input  logic [REG_W-1:0] mem_rdata
);

  localparam int SYNC_STAGES = 2;

  // Reset asserts asynchronously, releases on a clock edge.
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  state_e           st_q,  st_n;
  logic [REG_W-1:0] pa_q,  pa_n;
  logic [REG_W-1:0] pb_q,  pb_n;
  logic [REG_W-1:0] cnt_q, cnt_n;
  logic [REG_W-1:0] hi_q,  hi_n;
  logic [REG_W-1:0] mid_q, mid_n;
  logic [REG_W-1:0] lo_q,  lo_n;
  logic             s_q,   s_n;
  logic             o_q,   o_n;
  logic [REG_W-1:0] opa_q, opa_n;
  logic [1:0]       sz_q,  sz_n;
  logic             reg_en;

  logic [REG_W-1:0] elem_val;
  logic [REG_W-1:0] sum_hi, sum_mid, sum_lo;
  logic             sum_neg, sum_ovf;
  logic [REG_W-1:0] cl_hi, cl_mid, cl_lo;
  logic [REG_W-1:0] stride;

  dotmac_sext #(.REG_W(REG_W)) u_sext (
    .sz  (sz_q),
    .raw (mem_rdata),
    .val (elem_val)
  );

  dotmac_accum #(.REG_W(REG_W)) u_accum (
    .hi      (hi_q),
    .mid     (mid_q),
    .lo      (lo_q),
    .op_a    (opa_q),
    .op_b    (elem_val),
    .sum_hi  (sum_hi),
    .sum_mid (sum_mid),
    .sum_lo  (sum_lo),
    .sum_neg (sum_neg),
    .sum_ovf (sum_ovf)
  );

  dotmac_clamp #(.REG_W(REG_W)) u_clamp (
    .neg_sel (flag_s_in),
    .cl_hi   (cl_hi),
    .cl_mid  (cl_mid),
    .cl_lo   (cl_lo)
  );

  assign stride = REG_W'(elem_bytes(sz_q));

  always_comb begin
    st_n      = st_q;
    pa_n      = pa_q;
    pb_n      = pb_q;
    cnt_n     = cnt_q;
    hi_n      = hi_q;
    mid_n     = mid_q;
    lo_n      = lo_q;
    s_n       = s_q;
    o_n       = o_q;
    opa_n     = opa_q;
    sz_n      = sz_q;
    mem_rd_en = 1'b0;
    mem_addr  = pa_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          pa_n  = ptr_a_in;
          pb_n  = ptr_b_in;
          cnt_n = count_in;
          hi_n  = acc_hi_in;
          mid_n = acc_mid_in;
          lo_n  = acc_lo_in;
          s_n   = flag_s_in;
          o_n   = flag_o_in;
          sz_n  = elem_sz;
          st_n  = ST_FIN;
          if (cmd == CMD_SAT) begin
            if (flag_o_in) begin
              hi_n  = cl_hi;
              mid_n = cl_mid;
              lo_n  = cl_lo;
            end
          end else if (count_in != '0) begin
            o_n  = 1'b0;
            st_n = ST_FETCH_A;
          end
        end
      end
      ST_FETCH_A: begin
        mem_rd_en = 1'b1;
        mem_addr  = pa_q;
        st_n      = ST_FETCH_B;
      end
      ST_FETCH_B: begin
        mem_rd_en = 1'b1;
        mem_addr  = pb_q;
        opa_n     = elem_val;
        st_n      = ST_ACC;
      end
      ST_ACC: begin
        hi_n  = sum_hi;
        mid_n = sum_mid;
        lo_n  = sum_lo;
        pa_n  = pa_q + stride;
        pb_n  = pb_q + stride;
        cnt_n = cnt_q - REG_W'(1);
        if (cnt_q == REG_W'(1)) begin
          s_n  = sum_neg;
          o_n  = sum_ovf;
          st_n = ST_FIN;
        end else begin
          st_n = ST_FETCH_A;
        end
      end
      ST_FIN:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  assign reg_en = (st_q != ST_IDLE) | start;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q  <= ST_IDLE;
      pa_q  <= '0;
      pb_q  <= '0;
      cnt_q <= '0;
      hi_q  <= '0;
      mid_q <= '0;
      lo_q  <= '0;
      s_q   <= 1'b0;
      o_q   <= 1'b0;
      opa_q <= '0;
      sz_q  <= '0;
    end else if (reg_en) begin
      st_q  <= st_n;
      pa_q  <= pa_n;
      pb_q  <= pb_n;
      cnt_q <= cnt_n;
      hi_q  <= hi_n;
      mid_q <= mid_n;
      lo_q  <= lo_n;
      s_q   <= s_n;
      o_q   <= o_n;
      opa_q <= opa_n;
      sz_q  <= sz_n;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_FIN);
  assign ptr_a    = pa_q;
  assign ptr_b    = pb_q;
  assign count    = cnt_q;
  assign acc_hi   = hi_q;
  assign acc_mid  = mid_q;
  assign acc_lo   = lo_q;
  assign flag_s   = s_q;
  assign flag_o   = o_q;
  assign mem_size = sz_q;

endmodule

// File: rtl/dotmac_engine_chk.sv
module dotmac_engine_chk #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             cmd,
  input logic [REG_W-1:0] count_in,
  input logic [REG_W-1:0] acc_hi_in,
  input logic [REG_W-1:0] acc_mid_in,
  input logic [REG_W-1:0] acc_lo_in,
  input logic             flag_o_in,
  input logic             busy,
  input logic             done,
  input logic [REG_W-1:0] ptr_a,
  input logic [REG_W-1:0] count,
  input logic [REG_W-1:0] acc_hi,
  input logic [REG_W-1:0] acc_mid,
  input logic [REG_W-1:0] acc_lo,
  input logic             flag_s,
  input logic             flag_o,
  input logic             mem_rd_en
);

  logic mac_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              mac_run_q <= 1'b0;
    else if (start && !busy) mac_run_q <= (cmd == 1'b0) && (count_in != '0);
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(acc_hi) && $stable(acc_lo) && $stable(ptr_a) && $stable(flag_o)));

  // R10
  rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (busy && !done));

  // R5
  o_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !cmd && (count_in != '0)) |=> !flag_o);

  // R1
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !cmd && (count_in == '0)) |=>
      (acc_hi == $past(acc_hi_in) && acc_mid == $past(acc_mid_in) &&
       acc_lo == $past(acc_lo_in) && flag_o == $past(flag_o_in)));

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cmd && !flag_o_in) |=>
      (acc_hi == $past(acc_hi_in) && acc_mid == $past(acc_mid_in) &&
       acc_lo == $past(acc_lo_in)));

  // R5
  end_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mac_run_q) |->
      (flag_o == ((acc_hi != '0) && (acc_hi != '1)) && flag_s == acc_hi[REG_W-1]));

  // R4
  end_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mac_run_q) |-> (count == '0));

endmodule

bind dotmac_engine dotmac_engine_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/dotmac_engine_tb.sv
module dotmac_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int REG_W      = 32;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic             cmd;
  logic [1:0]       elem_sz;
  logic [REG_W-1:0] ptr_a_in, ptr_b_in, count_in;
  logic [REG_W-1:0] acc_hi_in, acc_mid_in, acc_lo_in;
  logic             flag_s_in, flag_o_in;
  logic             busy, done;
  logic [REG_W-1:0] ptr_a, ptr_b, count, acc_hi, acc_mid, acc_lo;
  logic             flag_s, flag_o;
  logic             mem_rd_en;
  logic [REG_W-1:0] mem_addr;
  logic [1:0]       mem_size;
  logic [REG_W-1:0] mem_rdata;

  logic [7:0] mem [256];
  int n_checks;
  int n_fail;
  int rd_cnt;

  dotmac_engine #(.REG_W(REG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .elem_sz(elem_sz),
    .ptr_a_in(ptr_a_in), .ptr_b_in(ptr_b_in), .count_in(count_in),
    .acc_hi_in(acc_hi_in), .acc_mid_in(acc_mid_in), .acc_lo_in(acc_lo_in),
    .flag_s_in(flag_s_in), .flag_o_in(flag_o_in),
    .busy(busy), .done(done), .ptr_a(ptr_a), .ptr_b(ptr_b), .count(count),
    .acc_hi(acc_hi), .acc_mid(acc_mid), .acc_lo(acc_lo),
    .flag_s(flag_s), .flag_o(flag_o),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model: always returns four bytes, so narrow reads carry live upper bits.
  always @(posedge clk) begin
    if (mem_rd_en) begin
      logic [7:0] ix;
      ix = mem_addr[7:0];
      mem_rdata <= {mem[ix + 8'd3], mem[ix + 8'd2], mem[ix + 8'd1], mem[ix]};
    end
    if (mem_rd_en) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 3'd1 : (sz == 2'd1) ? 3'd2 : 3'd4;
  endfunction

  function automatic logic signed [31:0] elem_at(input logic [31:0] addr, input logic [1:0] sz);
    logic [7:0] ix;
    logic signed [7:0]  b;
    logic signed [15:0] h;
    logic signed [31:0] w;
    ix = addr[7:0];
    b  = mem[ix];
    h  = {mem[ix + 8'd1], mem[ix]};
    w  = {mem[ix + 8'd3], mem[ix + 8'd2], mem[ix + 8'd1], mem[ix]};
    if (sz == 2'd0)      return b;
    else if (sz == 2'd1) return h;
    else                 return w;
  endfunction

  task automatic run(input string tag, input logic c, input logic [1:0] sz,
                     input logic [31:0] pa, input logic [31:0] pb, input logic [31:0] n,
                     input logic [31:0] hi, input logic [31:0] mid, input logic [31:0] lo,
                     input logic s, input logic o, input bit poke);
    logic signed [95:0] acc;
    logic [31:0] pa_e, pb_e, n_e;
    logic s_e, o_e;
    int lat_e, rd_e, lat;
    acc = {hi, mid, lo};
    pa_e = pa; pb_e = pb; n_e = n; s_e = s; o_e = o; lat_e = 1; rd_e = 0;
    if (c == 1'b1) begin
      if (o) acc = s ? {32'h0, 32'h7FFFFFFF, 32'hFFFFFFFF}
                     : {32'hFFFFFFFF, 32'h80000000, 32'h0};
    end else if (n != 0) begin
      for (int i = 0; i < int'(n); i++) begin
        longint prod;
        prod = longint'(elem_at(pa + i * nbytes(sz), sz)) * longint'(elem_at(pb + i * nbytes(sz), sz));
        acc = acc + {{32{prod[63]}}, prod};
      end
      pa_e = pa + n * nbytes(sz);
      pb_e = pb + n * nbytes(sz);
      n_e  = 0;
      s_e  = acc[95];
      o_e  = (acc[95:64] != 32'h0) && (acc[95:64] != 32'hFFFFFFFF);
      lat_e = 3 * int'(n) + 1;
      rd_e  = 2 * int'(n);
    end
    @(negedge clk);
    cmd = c; elem_sz = sz; ptr_a_in = pa; ptr_b_in = pb; count_in = n;
    acc_hi_in = hi; acc_mid_in = mid; acc_lo_in = lo; flag_s_in = s; flag_o_in = o;
    start = 1'b1;
    rd_cnt = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 1000) begin
      if (poke && lat == 2) begin
        // R9: a start while busy must be ignored
        start = 1'b1; count_in = 32'd5; acc_hi_in = 32'h12345678; ptr_a_in = 32'h40;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    chk({"R9 latency ", tag}, 96'(lat), 96'(lat_e));
    chk({"R3 R6 R7 R8 accumulator ", tag}, {acc_hi, acc_mid, acc_lo}, acc);
    chk({"R4 pointer a ", tag}, 96'(ptr_a), 96'(pa_e));
    chk({"R4 pointer b ", tag}, 96'(ptr_b), 96'(pb_e));
    chk({"R4 count ", tag}, 96'(count), 96'(n_e));
    chk({"R5 flags ", tag}, 96'({flag_s, flag_o}), 96'({s_e, o_e}));
    chk({"R10 reads ", tag}, 96'(rd_cnt), 96'(rd_e));
    @(negedge clk);
    chk({"R9 done pulse ", tag}, 96'({busy, done}), 96'(0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0; n_fail = 0; rd_cnt = 0;
    start = 0; cmd = 0; elem_sz = 0; ptr_a_in = 0; ptr_b_in = 0; count_in = 0;
    acc_hi_in = 0; acc_mid_in = 0; acc_lo_in = 0; flag_s_in = 0; flag_o_in = 0;
    mem_rdata = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 73 + 29) ^ 8'(i >> 3);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset idle", 96'({busy, done, mem_rd_en}), 96'(0));
    chk("R3 reset accumulator", {acc_hi, acc_mid, acc_lo}, 96'(0));

    // R1: zero count leaves everything including a set overflow flag
    run("R1 zero count", 1'b0, 2'd2, 32'h10, 32'h20, 32'd0,
        32'hFFFFFFF0, 32'h1234, 32'h5678, 1'b1, 1'b1, 1'b0);

    // R2 R3 R4 R5: every width code, counts 1..6, alternating start state
    for (int sz = 0; sz < 4; sz++) begin
      for (int n = 1; n <= 6; n++) begin
        run("R2 sweep", 1'b0, 2'(sz), 32'(n * 11), 32'(100 + n * 7), 32'(n),
            (n % 2) ? 32'hFFFFFFFF : 32'h0, 32'(n * 32'h01010101), 32'hDEADBEEF ^ 32'(sz),
            1'b0, 1'(n % 2), 1'b0);
      end
    end

    // R2 R3: grid of signed byte pairs including both extremes
    for (int a = -128; a < 128; a += 5) begin
      for (int k = 0; k < 4; k++) begin
        int bv;
        bv = (k == 0) ? -128 : (k == 1) ? -1 : (k == 2) ? 1 : 127;
        mem[0]   = 8'(a);
        mem[128] = 8'(bv);
        run("R2 byte grid", 1'b0, 2'd0, 32'd0, 32'd128, 32'd1,
            32'h0, 32'h0, 32'h10, 1'b0, 1'b0, 1'b0);
      end
    end
    mem[127] = 8'h7F;
    mem[128] = 8'h80;
    run("R2 byte extremes", 1'b0, 2'd0, 32'd127, 32'd128, 32'd1, 0, 0, 0, 1'b0, 1'b0, 1'b0);

    // R3 carry into upper word, then R7 saturate
    mem[200] = 8'd3; mem[201] = 8'd5;
    run("R3 carry", 1'b0, 2'd0, 32'd200, 32'd201, 32'd1,
        32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0);
    chk("R5 carry overflow", 96'({acc_hi, flag_s, flag_o}), 96'({32'd1, 1'b0, 1'b1}));
    run("R7 saturate positive", 1'b1, 2'd0, 32'd7, 32'd9, 32'd3,
        acc_hi, acc_mid, acc_lo, 1'b0, 1'b1, 1'b0);
    chk("R7 clamp pattern", {acc_hi, acc_mid, acc_lo}, {32'hFFFFFFFF, 32'h80000000, 32'h0});

    // R3 borrow out of upper range, then R6 saturate
    mem[200] = 8'hFF; mem[201] = 8'd1;
    run("R3 borrow", 1'b0, 2'd0, 32'd200, 32'd201, 32'd1,
        32'hFFFFFFFF, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
    chk("R5 borrow overflow", 96'({acc_hi, flag_s, flag_o}), 96'({32'hFFFFFFFE, 1'b1, 1'b1}));
    run("R6 saturate negative", 1'b1, 2'd1, 32'd1, 32'd2, 32'd4,
        acc_hi, acc_mid, acc_lo, 1'b1, 1'b1, 1'b0);
    chk("R6 clamp pattern", {acc_hi, acc_mid, acc_lo}, {32'h0, 32'h7FFFFFFF, 32'hFFFFFFFF});

    // R8 saturate with overflow clear
    run("R8 saturate idle", 1'b1, 2'd2, 32'h33, 32'h44, 32'd2,
        32'h00000123, 32'h456789AB, 32'hCDEF0123, 1'b1, 1'b0, 1'b0);

    // R9 start while busy ignored
    run("R9 busy start", 1'b0, 2'd1, 32'd8, 32'd60, 32'd4,
        32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule